// File: doc/BRIEF.md
# Table-Driven Control Sequencer

This block steps through a small byte-addressed program memory, one four-byte row at a time. Each row gives a 16-bit control word, which goes straight to the outputs, and a 16-bit hold count. The row is held for a number of clocks set by that count, and then the next row is loaded. A frame begins when the start input rises while the block is idle. The frame ends after a row that carries the end marker, or after the last row in the memory, whichever comes first. An abort input cuts a running frame short.

A byte-wide configuration port writes and reads the program memory. Any access made while a frame is running is refused. After reset, a guard interval has to pass before a start is honoured.

The control state machine has three states. SEQ_GUARD is entered at reset and counts out the guard interval. It moves to SEQ_IDLE when the count expires (transition "guard expired"). SEQ_IDLE waits for a start edge and moves to SEQ_RUN on one (transition "frame start"). SEQ_RUN counts down each row and loads the following row when the count reaches zero (transition "row advance"). It returns to SEQ_IDLE for three reasons: the end marker is found ("frame end"), the last row is finished ("table exhausted"), or abort is high ("abort").

Top module: `tt_sequencer`

## Requirements
- R1: After reset, busy is 0, ctrl_out is 0, cfg_rdata is 0, and every memory byte reads back as 0x00.
- R2: A rising edge of start_in sampled at any of the first 200 clock edges after reset release does not start a frame.
- R3: A rising edge of start_in that is sampled while idle starts a frame at row 0. In the cycle after that edge, busy is 1 and ctrl_out holds row 0's control word.
- R4: Row r occupies bytes 4r to 4r+3. Byte 4r+0 is hold[7:0] and byte 4r+1 is hold[15:8]. Byte 4r+2 is ctrl[7:0] and byte 4r+3 is ctrl[15:8]. While the row is active, ctrl_out equals its ctrl word.
- R5: A row with hold value H stays on ctrl_out for H+1 clocks, and a hold of 0 counts as 1. Every row therefore lasts at least 2 clocks.
- R6: If the active row has ctrl[15] set (the end marker), busy and ctrl_out return to 0 in the cycle after that row's last clock, and no later row runs.
- R7: If no end marker is found, the frame stops after row 31 (address 0x7C).
- R8: A rising edge of start_in while busy is ignored. It neither restarts nor extends the frame.
- R9: While idle, a write (cfg_en=1, cfg_we=1) stores cfg_wdata at cfg_addr. A read (cfg_en=1, cfg_we=0) shows the byte on cfg_rdata in the following cycle.
- R10: While busy, writes are dropped and reads return 0x00.
- R11: If abort_in is high at a clock edge while busy, busy and ctrl_out are 0 in the next cycle. The next start edge then starts a fresh frame from row 0.
- R12: The hold count uses its full 16-bit width. A hold of 1016 keeps the row for 1017 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_in | input | 1 | Frame start request, edge detected |
| abort_in | input | 1 | Ends a running frame |
| cfg_en | input | 1 | Configuration access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 7 | Memory byte address |
| cfg_wdata | input | 8 | Write byte |
| cfg_rdata | output | 8 | Read byte, registered |
| ctrl_out | output | 16 | Control word of the active row |
| busy | output | 1 | High while a frame runs |

## Verification
Every result is due one clock after the edge that causes it. After the start edge, ctrl_out carries row 0 at once. Busy falls in the cycle that follows a row's final clock. The abort result is due one cycle after the edge that samples abort. Read data appears one cycle after the read strobe. The bench changes inputs on falling edges and samples on the next falling edge. For each row it compares ctrl_out on every clock of that row's expected span, which it computes from the hold values it wrote. For frame length it counts the busy cycles and compares the count with the expected sum of row lengths.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int CTRL_BITS = 16;
    localparam int HOLD_BITS = 16;
    localparam int END_MARK  = 15;

    typedef enum logic [1:0] {
        SEQ_GUARD = 2'd0,
        SEQ_IDLE  = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/tt_store.sv
module tt_store #(
    parameter int TBL_BYTES = 128,
    parameter int ROW_BYTES = 4,
    localparam int AW = $clog2(TBL_BYTES),
    localparam int BW = $clog2(ROW_BYTES),
    localparam int RW = AW - BW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lock,
    input  logic                   cfg_en,
    input  logic                   cfg_we,
    input  logic [AW-1:0]          cfg_addr,
    input  logic [7:0]             cfg_wdata,
    output logic [7:0]             cfg_rdata,
    input  logic [RW-1:0]          row_sel,
    output logic [ROW_BYTES*8-1:0] row_data
);
    logic [7:0] mem [TBL_BYTES];
    logic [7:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TBL_BYTES; i++) mem[i] <= '0;
            rdata_q <= '0;
        end else if (cfg_en) begin
            if (cfg_we) begin
                if (!lock) mem[cfg_addr] <= cfg_wdata;
            end else begin
                rdata_q <= lock ? 8'h00 : mem[cfg_addr];
            end
        end
    end

    assign cfg_rdata = rdata_q;

    for (genvar b = 0; b < ROW_BYTES; b++) begin : g_byte
        assign row_data[b*8 +: 8] = mem[{row_sel, BW'(b)}];
    end

    // R10: a read while locked returns zero
    assert_locked_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !cfg_we && lock) |=> (cfg_rdata == 8'h00));
endmodule

// File: rtl/tt_edge.sv
module tt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    assign rise = level_in & ~level_q;
endmodule

// File: rtl/tt_engine.sv
module tt_engine
    import tt_pkg::*;
#(
    parameter int ROWS      = 32,
    parameter int CTRL_W    = CTRL_BITS,
    parameter int DLY_W     = HOLD_BITS,
    parameter int END_BIT   = END_MARK,
    parameter int GUARD_CYC = 200,
    localparam int RW = $clog2(ROWS),
    localparam int GW = $clog2(GUARD_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rise,
    input  logic              abort,
    input  logic [CTRL_W-1:0] row_ctrl,
    input  logic [DLY_W-1:0]  row_dly,
    output logic [RW-1:0]     row_sel,
    output logic [CTRL_W-1:0] ctrl_out,
    output logic              busy
);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    seq_state_t        state_q, state_d;
    logic [RW-1:0]     row_q, row_d;
    logic [DLY_W-1:0]  cnt_q, cnt_d;
    logic [CTRL_W-1:0] ctrl_q, ctrl_d;
    logic [GW-1:0]     guard_q, guard_d;
    logic [DLY_W-1:0]  eff_dly;

    assign eff_dly = (row_dly == '0) ? DLY_W'(1) : row_dly;
    assign row_sel = (state_q == SEQ_RUN) ? row_q + 1'b1 : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_GUARD;
            row_q   <= '0;
            cnt_q   <= '0;
            ctrl_q  <= '0;
            guard_q <= '0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
            cnt_q   <= cnt_d;
            ctrl_q  <= ctrl_d;
            guard_q <= guard_d;
        end
    end

    always_comb begin
        state_d = state_q;
        row_d   = row_q;
        cnt_d   = cnt_q;
        ctrl_d  = ctrl_q;
        guard_d = guard_q;
        unique case (state_q)
            SEQ_GUARD: begin
                if (guard_q == GW'(GUARD_CYC - 1)) state_d = SEQ_IDLE;
                else                               guard_d = guard_q + 1'b1;
            end
            SEQ_IDLE: begin
                if (start_rise) begin
                    state_d = SEQ_RUN;
                    row_d   = '0;
                    ctrl_d  = row_ctrl;
                    cnt_d   = eff_dly;
                end
            end
            SEQ_RUN: begin
                if (abort) begin
                    state_d = SEQ_IDLE;
                    ctrl_d  = '0;
                    cnt_d   = '0;
                end else if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (ctrl_q[END_BIT] || row_q == LAST_ROW) begin
                    state_d = SEQ_IDLE;
                    ctrl_d  = '0;
                end else begin
                    row_d  = row_q + 1'b1;
                    ctrl_d = row_ctrl;
                    cnt_d  = eff_dly;
                end
            end
            default: state_d = SEQ_GUARD;
        endcase
    end

    assign ctrl_out = ctrl_q;
    assign busy     = (state_q == SEQ_RUN);

    // R2: no frame can begin during the guard interval
    assert_guard_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_GUARD) |=> !busy);
    // R3: an accepted start edge makes the block busy
    assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && start_rise) |=> busy);
    // R5: mid-row the outputs do not move
    assert_row_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0 && !abort) |=> (busy && $stable(ctrl_out)));
    // R6: end marker on a finished row ends the frame
    assert_end_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q == '0 && ctrl_out[END_BIT] && !abort) |=> (!busy && ctrl_out == '0));
    // R11: abort ends the frame on the next cycle
    assert_abort_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (!busy && ctrl_out == '0));
    // R8: a start edge while running does not restart at row 0
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_rise && cnt_q != '0 && !abort) |=> $stable(row_q));
endmodule

// File: rtl/tt_sequencer.sv
module tt_sequencer #(
    parameter int TBL_BYTES = 128,
    parameter int ROW_BYTES = 4,
    parameter int DLY_W     = 16,
    parameter int GUARD_CYC = 200
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_in,
    input  logic                          abort_in,
    input  logic                          cfg_en,
    input  logic                          cfg_we,
    input  logic [$clog2(TBL_BYTES)-1:0]  cfg_addr,
    input  logic [7:0]                    cfg_wdata,
    output logic [7:0]                    cfg_rdata,
    output logic [ROW_BYTES*8-DLY_W-1:0]  ctrl_out,
    output logic                          busy
);
    localparam int ROW_W  = ROW_BYTES * 8;
    localparam int CTRL_W = ROW_W - DLY_W;
    localparam int ROWS   = TBL_BYTES / ROW_BYTES;
    localparam int RW     = $clog2(ROWS);

    logic              start_rise;
    logic [RW-1:0]     row_sel;
    logic [ROW_W-1:0]  row_data;

    tt_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (start_in),
        .rise     (start_rise)
    );

    tt_store #(
        .TBL_BYTES (TBL_BYTES),
        .ROW_BYTES (ROW_BYTES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock      (busy),
        .cfg_en    (cfg_en),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .row_sel   (row_sel),
        .row_data  (row_data)
    );

    tt_engine #(
        .ROWS      (ROWS),
        .CTRL_W    (CTRL_W),
        .DLY_W     (DLY_W),
        .END_BIT   (CTRL_W - 1),
        .GUARD_CYC (GUARD_CYC)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_rise (start_rise),
        .abort      (abort_in),
        .row_ctrl   (row_data[ROW_W-1:DLY_W]),
        .row_dly    (row_data[DLY_W-1:0]),
        .row_sel    (row_sel),
        .ctrl_out   (ctrl_out),
        .busy       (busy)
    );
endmodule

// File: tb/sim_tt_sequencer.sv
module sim_tt_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_in = 1'b0, abort_in = 1'b0;
    logic cfg_en = 1'b0, cfg_we = 1'b0;
    logic [6:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [15:0] ctrl_out;
    logic busy;

    int n_chk = 0;
    int n_err = 0;

    // row program: {ctrl, hold}
    localparam int NROW = 6;
    localparam logic [31:0] PROG [NROW] = '{
        {16'h0013, 16'd0},
        {16'h0200, 16'd1},
        {16'h00A4, 16'd5},
        {16'h4001, 16'd2},
        {16'h8800, 16'd3},
        {16'h1234, 16'd7}
    };

    always #2 clk = ~clk;

    tt_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .start_in(start_in), .abort_in(abort_in),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ctrl_out(ctrl_out), .busy(busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int addr, input int data);
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b1; cfg_addr = 7'(addr); cfg_wdata = 8'(data);
        @(negedge clk);
        cfg_en = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input int addr, output int data);
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b0; cfg_addr = 7'(addr);
        @(negedge clk);
        cfg_en = 1'b0;
        data = int'(cfg_rdata);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_in = 1'b1;
        @(negedge clk); start_in = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic int row_len(input logic [15:0] h);
        return (h == 16'd0) ? 2 : int'(h) + 1;
    endfunction

    // walk the program: every clock of each row is compared
    task automatic frame_check(input string req);
        pulse_start();
        for (int r = 0; r < NROW; r++) begin
            int bad = 0;
            for (int c = 0; c < row_len(PROG[r][15:0]); c++) begin
                if (!busy || ctrl_out != PROG[r][31:16]) bad++;
                @(negedge clk);
            end
            chk(req, $sformatf("row %0d mismatched clocks", r), bad, 0);
            if (PROG[r][31]) break;
        end
        chk("R6", "busy after end row", int'(busy), 0);
        chk("R6", "ctrl after end row", int'(ctrl_out), 0);
    endtask

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int v, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "ctrl after reset", int'(ctrl_out), 0);
        chk("R1", "rdata after reset", int'(cfg_rdata), 0);
        // R2 start edge inside guard interval
        repeat (40) @(negedge clk);
        pulse_start();
        repeat (3) @(negedge clk);
        chk("R2", "busy after guarded start", int'(busy), 0);
        cfg_read(5, v);
        chk("R1", "memory byte after reset", v, 0);
        repeat (200) @(negedge clk);

        // R4 R9 write program from the vector table, then read back
        for (int r = 0; r < NROW; r++)
            for (int b = 0; b < 4; b++)
                cfg_write(4 * r + b, int'(PROG[r][8*b +: 8]));
        for (int r = 0; r < NROW; r++)
            for (int b = 0; b < 4; b++) begin
                cfg_read(4 * r + b, v);
                chk("R9", $sformatf("readback byte %0d", 4 * r + b), v, int'(PROG[r][8*b +: 8]));
            end

        // R3 R4 R5 R6 full frame
        frame_check("R5");

        // R10 access refused while busy
        pulse_start();
        cfg_write(0, 8'hFF);
        cfg_read(2, v);
        chk("R10", "read while busy", v, 0);
        count_busy(n);
        cfg_read(0, v);
        chk("R10", "write while busy dropped", v, 0);

        // R8 start edge while running
        pulse_start();
        pulse_start();
        count_busy(n);
        chk("R8", "remaining busy cycles", n, 15);
        repeat (3) @(negedge clk);
        chk("R8", "no restart", int'(busy), 0);

        // R11 abort mid-frame, then a fresh frame
        pulse_start();
        repeat (2) @(negedge clk);
        abort_in = 1'b1;
        @(negedge clk);
        abort_in = 1'b0;
        chk("R11", "busy after abort", int'(busy), 0);
        chk("R11", "ctrl after abort", int'(ctrl_out), 0);
        frame_check("R11");

        // R7 no end marker: runs through row 31
        cfg_write(19, 8'h08);
        pulse_start();
        count_busy(n);
        chk("R7", "frame length without marker", n, 77);

        // R12 long hold
        cfg_write(19, 8'h88);
        cfg_write(12, 8'hF8);
        cfg_write(13, 8'h03);
        pulse_start();
        count_busy(n);
        chk("R12", "frame length with hold 1016", n, 1031);
        chk("R3", "idle ctrl after long frame", int'(ctrl_out), 0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule